// File: doc/BRIEF.md
# Alternating-pattern watchdog timer

The block is a small memory-mapped watchdog with 16-bit registers. Software programs a reload count and an enable bit. Once enabled, a down-counter steps once per tick of a slow timebase. The timebase runs at TICK_HZ, 500 Hz by default. A prescaler inside the block derives it from the system clock. If the counter reaches zero while the watchdog is enabled, the block raises a reset request. That request stays high until the block itself is reset.

Software keeps the watchdog alive by writing the trigger register. Not every write counts. Only a write of the exact bitwise complement of the value the register currently holds is accepted as a kick. Accepted values therefore alternate between 0x5555 and 0xAAAA. Reading the trigger register returns the last accepted value, so software can compute the next one. Any other trigger write is dropped and raises a sticky error flag. A later valid kick clears that flag.

The divisor is CLK_HZ / TICK_HZ, so a count of N gives a timeout of about N / 500 seconds. The largest count is 0x7FFF, which is roughly 65 seconds.

Top module: `wdog_alt_kick`

## Requirements
- R1: After reset, the timeout register (byte offset 0x10) reads 0x7FFF (disabled, count 0x7FFF). The trigger register (byte offset 0x14) reads 0x5555. The reset request and the error flag are low.
- R2: A write to offset 0x10 stores bit 15 as the enable bit and bits 14:0 as the reload count. Reading offset 0x10 returns exactly the stored value.
- R3: Suppose a write to offset 0x10 sets enable with count N ≥ 1, and no kick follows. The reset request then rises 2 + N·DIV clock cycles after the write edge. DIV = CLK_HZ / TICK_HZ.
- R4: The reset request stays high until reset, even if a later write clears the enable bit.
- R5: While the enable bit is 0, the counter does not advance and no reset request is raised.
- R6: A trigger write whose data is the bitwise inverse of the current trigger value is a valid kick. It updates the trigger value and clears the error flag. It also reloads the counter, so the reset request rises 2 + N·DIV cycles after the kick edge.
- R7: Any other trigger write leaves the trigger value unchanged and sets the error flag. It does not reload the counter, so the original expiry time still holds.
- R8: Clearing enable freezes the count. Setting enable again through a timeout write reloads the counter, and expiry is then 2 + N·DIV cycles after that write.
- R9: A write that enables the watchdog with count 0 raises the reset request 2 cycles after the write edge.
- R10: Writes to any offset other than 0x10 and 0x14 change no register. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| kick_err | output | 1 | Sticky flag set by a rejected trigger write |
| rst_req | output | 1 | Sticky reset request raised on expiry |

## Verification
A register write takes effect at the clock edge that samples the strobe. The read data and the error flag therefore change right after that edge, and the bench samples them at the following falling edge. A reload is registered once before it reaches the counter, and expiry is registered once more, so the reset request is due exactly 2 + N·DIV edges after the write or kick edge. The bench counts edges from that write edge and compares the count against this formula for a sweep of counts. It also checks kicks and rejected writes made in the middle of a count against the remaining time it works out itself.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_TMO  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 8'h14;
  localparam logic [REG_W-1:0]  TRIG_INIT = 16'h5555;
  localparam logic [REG_W-2:0]  COUNT_INIT = 15'h7FFF;

  typedef struct packed {
    logic              en;
    logic [REG_W-2:0]  count;
  } tmo_reg_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              wd_en,
  output logic [REG_W-2:0]  reload_val,
  output logic              reload_req,
  output logic              kick_err
);
  tmo_reg_t         tmo_q, tmo_d;
  logic [REG_W-1:0] trig_q, trig_d;
  logic             err_q, err_d;
  logic             rld_q, rld_d;

  logic wr_tmo, wr_trig, kick_ok, kick_bad;

  assign wr_tmo   = reg_wr && (reg_addr == OFS_TMO);
  assign wr_trig  = reg_wr && (reg_addr == OFS_TRIG);
  assign kick_ok  = wr_trig && (reg_wdata == ~trig_q);
  assign kick_bad = wr_trig && !kick_ok;

  always_comb begin
    tmo_d  = tmo_q;
    trig_d = trig_q;
    err_d  = err_q;
    rld_d  = 1'b0;
    if (wr_tmo) begin
      tmo_d = tmo_reg_t'(reg_wdata);
      rld_d = 1'b1;
    end
    if (kick_ok) begin
      trig_d = reg_wdata;
      err_d  = 1'b0;
      rld_d  = 1'b1;
    end else if (kick_bad) begin
      err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= '{en: 1'b0, count: COUNT_INIT};
      trig_q <= TRIG_INIT;
      err_q  <= 1'b0;
      rld_q  <= 1'b0;
    end else begin
      tmo_q  <= tmo_d;
      trig_q <= trig_d;
      err_q  <= err_d;
      rld_q  <= rld_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_TMO:  reg_rdata = tmo_q;
      OFS_TRIG: reg_rdata = trig_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign wd_en      = tmo_q.en;
  assign reload_val = tmo_q.count;
  assign reload_req = rld_q;
  assign kick_err   = err_q;

  AST_BAD_KICK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_bad |=> ($stable(trig_q) && err_q)); // R7
  AST_TRIG_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q == 16'h5555) || (trig_q == 16'hAAAA)); // R6
  AST_OTHER_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !wr_tmo && !wr_trig) |=> ($stable(tmo_q) && $stable(trig_q) && $stable(err_q))); // R10
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] pre_q, pre_d;
      logic          last;

      assign last = (pre_q == PW'(DIV - 1));

      always_comb begin
        pre_d = pre_q;
        if (clear)     pre_d = '0;
        else if (run)  pre_d = last ? '0 : pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick = run && !clear && last;

      AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PW'(DIV - 1)); // R3
      AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pre_q == '0)); // R6
    end else begin : g_nodiv
      assign tick = run && !clear;
    end
  endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_en,
  input  logic             tick,
  input  logic             reload_req,
  input  logic [CNT_W-1:0] reload_val,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (reload_req)
      cnt_d = reload_val;
    else if (wd_en && tick && !at_zero)
      cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    exp_d = exp_q;
    if (wd_en && at_zero && !reload_req)
      exp_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign rst_req = exp_q;

  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> (cnt_q == $past(reload_val))); // R6
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en && !reload_req) |=> ($stable(cnt_q) && $stable(exp_q))); // R5
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en && tick && !reload_req && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req); // R4
endmodule

// File: rtl/wdog_alt_kick.sv
module wdog_alt_kick
  import wdog_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int TICK_HZ = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              kick_err,
  output logic              rst_req
);
  localparam int DIV   = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;
  localparam int CNT_W = REG_W - 1;

  logic             rst_sync_n;
  logic             wd_en, reload_req, tick;
  logic [CNT_W-1:0] reload_val;

  wdog_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdog_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .wd_en      (wd_en),
    .reload_val (reload_val),
    .reload_req (reload_req),
    .kick_err   (kick_err)
  );

  wdog_prescaler #(.DIV(DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (wd_en),
    .clear (reload_req),
    .tick  (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wd_en      (wd_en),
    .tick       (tick),
    .reload_req (reload_req),
    .reload_val (reload_val),
    .rst_req    (rst_req)
  );
endmodule

// File: tb/wdog_alt_kick_tb_top.sv
module wdog_alt_kick_tb_top;
  localparam int CLK_HZ = 2000;
  localparam int DIV    = CLK_HZ / 500;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        kick_err;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  logic [15:0] trig_exp;

  always #2.5 clk = ~clk;

  wdog_alt_kick #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kick_err(kick_err),
    .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    trig_exp = 16'h5555;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_expiry(input int limit, output int k);
    k = 0;
    while (!rst_req && k < limit) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    logic [15:0] rv;
    int k;
    do_reset();

    rd(8'h10, rv); chk("R1 timeout reset", rv, 16'h7FFF);
    rd(8'h14, rv); chk("R1 trigger reset", rv, 16'h5555);
    chk("R1 rst_req reset", rst_req, 1'b0);
    chk("R1 err reset", kick_err, 1'b0);

    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = 16'h0001 << (i * 2);
      v = v & 16'h7FFF | 16'h0100;
      wr(8'h10, v);
      rd(8'h10, rv); chk("R2 readback", rv, v);
    end
    wr(8'h10, 16'h7FFF); rd(8'h10, rv); chk("R2 readback max", rv, 16'h7FFF);

    wr(8'h10, 16'h0001); idle(100);
    chk("R5 disabled no expiry", rst_req, 1'b0);

    wr(8'h12, 16'hFFFF); wr(8'h00, 16'h1234); wr(8'h15, 16'hAAAA);
    rd(8'h10, rv); chk("R10 timeout untouched", rv, 16'h0001);
    rd(8'h14, rv); chk("R10 trigger untouched", rv, 16'h5555);
    rd(8'h04, rv); chk("R10 other read", rv, 16'h0000);
    chk("R10 err untouched", kick_err, 1'b0);

    for (int n = 1; n <= 8; n++) begin
      do_reset();
      wr(8'h10, 16'h8000 | 16'(n));
      wait_expiry(1000, k);
      chk("R3 expiry latency", k, 2 + n * DIV);
    end
    wr(8'h10, 16'h0005); idle(40);
    chk("R4 sticky after disable", rst_req, 1'b1);

    do_reset();
    wr(8'h10, 16'h8000); wait_expiry(100, k);
    chk("R9 zero count latency", k, 2);

    do_reset();
    for (int i = 0; i < 4; i++) begin
      logic [15:0] bad [4];
      bad[0] = trig_exp; bad[1] = 16'h0000; bad[2] = 16'hFFFF; bad[3] = ~trig_exp ^ 16'h0001;
      wr(8'h14, bad[i]);
      chk("R7 err set", kick_err, 1'b1);
      rd(8'h14, rv); chk("R7 trigger kept", rv, trig_exp);
      wr(8'h14, ~trig_exp); trig_exp = ~trig_exp;
      chk("R6 err cleared", kick_err, 1'b0);
      rd(8'h14, rv); chk("R6 trigger updated", rv, trig_exp);
    end

    for (int n = 2; n <= 5; n++) begin
      do_reset();
      wr(8'h10, 16'h8000 | 16'(n));
      idle(DIV + 3);
      wr(8'h14, ~trig_exp); trig_exp = ~trig_exp;
      wait_expiry(1000, k);
      chk("R6 kick reload latency", k, 2 + n * DIV);
    end

    for (int n = 2; n <= 5; n++) begin
      do_reset();
      wr(8'h10, 16'h8000 | 16'(n));
      idle(DIV + 3);
      wr(8'h14, trig_exp);
      wait_expiry(1000, k);
      chk("R7 bad kick no reload", k, 2 + n * DIV - (DIV + 4));
    end

    do_reset();
    wr(8'h10, 16'h8003); idle(5);
    wr(8'h10, 16'h0003); idle(60);
    chk("R8 frozen while disabled", rst_req, 1'b0);
    wr(8'h10, 16'h8003); wait_expiry(1000, k);
    chk("R8 reenable latency", k, 2 + 3 * DIV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule